// File: doc/BRIEF.md
# Multi-Lane Training Skew Compensator

This receiver block sits behind a parallel bus whose lanes can reach it many whole clock cycles apart. Once transmitter and receiver have agreed to train, the receiver raises a one-cycle training request. The transmitter then sends a pulse of ones on every lane at the same moment. Because the lanes have different delays, that pulse reaches the receiver in different cycles on different lanes.

The block stamps each lane with the value of a listen counter in the cycle where that lane first goes from 0 to 1. The lane with the highest stamp is the latest one, and it needs no delay. Every earlier lane is held back by the gap between its own stamp and the latest stamp. The delay comes from a per-lane shift register, and a tap selects how many cycles to use. After training, each word presented on the aligned outputs is the word that was launched on all lanes together. Training fails if a lane never arrives, or if a lane is too early to be compensated. Both cases raise an error flag in place of the trained flag. The design works only at whole-cycle granularity.

Top module: `lane_deskew`

## Requirements
- R1: After reset, `trained`, `train_err` and every bit of `lane_out` are 0.
- R2: While `trained` is 0, `lane_out` is all zeros, whatever `lane_in` carries.
- R3: In the cycle after `train_req` is sampled high, the block is listening. Each lane's arrival is the first cycle in which it is 1 after being 0 in the previous cycle. Any later 0-to-1 transitions on that lane do not change its measured arrival.
- R4: When every lane has arrived, `trained` rises within two cycles. From then on, `lane_out[i]` equals `lane_in[i]` delayed by (latest arrival minus arrival of lane i) cycles. As a result, all lanes present the same launched word at once, with no extra delay on the latest lane.
- R5: A lane that leads the latest lane by exactly `MAX_SKEW` cycles is still compensated, and training succeeds.
- R6: If any lane leads the latest lane by more than `MAX_SKEW` cycles, training ends with `train_err` at 1 and `trained` at 0.
- R7: If some lane has not arrived within `TIMEOUT` cycles of listening, training ends with `train_err` at 1 and `trained` at 0.
- R8: A sampled `train_req` clears both flags on the next cycle and starts a new measurement, even after an error or a completed training.
- R9: `trained` and `train_err` are never 1 together. Each holds its value until the next `train_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_req | input | 1 | One-cycle request that starts a training measurement |
| lane_in | input | LANES | Raw serial bit of each lane |
| lane_out | output | LANES | Skew-compensated lane bits, zero until trained |
| trained | output | 1 | Training finished and alignment is in force |
| train_err | output | 1 | Training failed on a timeout or on excess skew |

## Verification
A wrong arrival stamp or a wrong delay tap shows up at the ports the moment `trained` rises. From that cycle on, at least one lane of `lane_out` no longer matches the common launched stream. The data after the training pulse has frequent transitions, so such a lane disagrees within a few cycles. A wrong state decision shows up differently. Within the timeout window, either the flag pair settles to the wrong outcome, or outputs leak through while the block is untrained.

// File: rtl/lane_deskew.sv
module lane_deskew #(
  parameter int LANES    = 4,
  parameter int MAX_SKEW = 12,
  parameter int TIMEOUT  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_req,
  input  logic [LANES-1:0] lane_in,
  output logic [LANES-1:0] lane_out,
  output logic             trained,
  output logic             train_err
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam int DW = $clog2(MAX_SKEW + 1);

  typedef enum logic [2:0] {S_IDLE, S_LISTEN, S_EVAL, S_DONE, S_FAIL} st_t;
  st_t st;

  logic [CW-1:0]    cnt;
  logic [LANES-1:0] prev, arrived, rise, too_far;
  logic [CW-1:0]    stamp [LANES];
  logic [CW-1:0]    skew  [LANES];
  logic [DW-1:0]    dly   [LANES];
  logic [CW-1:0]    latest;

  assign rise      = lane_in & ~prev & ~arrived;
  assign trained   = (st == S_DONE);
  assign train_err = (st == S_FAIL);

  always_comb begin
    latest = '0;
    for (int i = 0; i < LANES; i++)
      if (stamp[i] > latest) latest = stamp[i];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [MAX_SKEW:1] sr;
    logic [MAX_SKEW:0] taps;
    assign skew[i]    = latest - stamp[i];
    assign too_far[i] = 32'(skew[i]) > 32'(MAX_SKEW);
    assign taps       = {sr, lane_in[i]};
    assign lane_out[i] = trained & taps[dly[i]];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sr <= '0;
      else        sr <= taps[MAX_SKEW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      prev    <= '0;
      arrived <= '0;
      for (int i = 0; i < LANES; i++) begin
        stamp[i] <= '0;
        dly[i]   <= '0;
      end
    end else begin
      prev <= lane_in;
      if (train_req) begin
        st      <= S_LISTEN;
        cnt     <= '0;
        arrived <= '0;
        for (int i = 0; i < LANES; i++) stamp[i] <= '0;
      end else begin
        case (st)
          S_LISTEN: begin
            arrived <= arrived | rise;
            for (int i = 0; i < LANES; i++)
              if (rise[i]) stamp[i] <= cnt;
            if (&(arrived | rise))                 st  <= S_EVAL;
            else if (32'(cnt) == 32'(TIMEOUT - 1)) st  <= S_FAIL;
            else                                   cnt <= cnt + 1'b1;
          end
          S_EVAL: begin
            if (|too_far) st <= S_FAIL;
            else begin
              st <= S_DONE;
              for (int i = 0; i < LANES; i++) dly[i] <= DW'(skew[i]);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             train_req,
  input logic [LANES-1:0] lane_out,
  input logic             trained,
  input logic             train_err
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!trained && !train_err && lane_out == '0)); // R1
  AST_ZERO_UNTRAINED: assert property (@(posedge clk) disable iff (!rst_n) !trained |-> lane_out == '0); // R2
  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) train_req |=> (!trained && !train_err)); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(trained && train_err)); // R9
  AST_TRAINED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (trained && !train_req) |=> trained); // R9
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (train_err && !train_req) |=> train_err); // R9
endmodule

bind lane_deskew lane_deskew_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .train_req(train_req),
  .lane_out(lane_out), .trained(trained), .train_err(train_err)
);

// File: tb/test_lane_deskew.sv
module test_lane_deskew;
  localparam int LANES = 4, MAX_SKEW = 12, TIMEOUT = 64;

  logic clk = 0, rst_n = 0, train_req = 0;
  logic [LANES-1:0] lane_in = '0, lane_out;
  logic trained, train_err;

  lane_deskew #(.LANES(LANES), .MAX_SKEW(MAX_SKEW), .TIMEOUT(TIMEOUT)) i_lane_deskew (
    .clk(clk), .rst_n(rst_n), .train_req(train_req), .lane_in(lane_in),
    .lane_out(lane_out), .trained(trained), .train_err(train_err));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, t = 0, ps = 1000000, maxlag = 0;
  int lag [LANES];
  logic [LANES-1:0] dead = '0;
  logic [LANES:0] sb [$];

  function automatic logic refbit(int x);
    if (x < ps) return 1'b0;
    if (x < ps + 4) return 1'b1;
    if (x < ps + 10) return 1'b0;
    return ((x * 13 + 5) % 7) < 3;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, t);
    end
  endtask

  // driver: drives lanes at negedge and pushes the expected aligned word
  task automatic step(logic req, logic cmp);
    @(negedge clk);
    train_req = req;
    for (int i = 0; i < LANES; i++) lane_in[i] = dead[i] ? 1'b0 : refbit(t - lag[i]);
    sb.push_back({cmp, {LANES{refbit(t - maxlag)}}});
    t++;
  endtask

  // monitor: pops expectations and compares just before the next edge
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      logic [LANES:0] e;
      e = sb.pop_front();
      if (e[LANES]) begin
        if (trained) check("R4 aligned lanes", 8'(lane_out), 8'(e[LANES-1:0]));
        else         check("R2 zero while untrained", 8'(lane_out), 8'h0);
        check("R9 flags exclusive", 8'(trained & train_err), 8'h0);
      end
    end
  end

  task automatic run_case(int l0, int l1, int l2, int l3, logic [LANES-1:0] dm,
                          logic ok, string req, int n);
    lag[0] = l0; lag[1] = l1; lag[2] = l2; lag[3] = l3; dead = dm;
    maxlag = 0;
    for (int i = 0; i < LANES; i++) if (!dm[i] && lag[i] > maxlag) maxlag = lag[i];
    ps = t + 3;
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    #1 check("R8 flags cleared after request", 8'({trained, train_err}), 8'h0);
    for (int k = 0; k < n; k++) step(1'b0, 1'b1);
    #1;
    if (ok) check(req, 8'({trained, train_err}), 8'h2);
    else    check(req, 8'({trained, train_err}), 8'h1);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < LANES; i++) lag[i] = 0;
    #5;
    check("R1 reset flags", 8'({trained, train_err}), 8'h0);
    check("R1 reset outputs", 8'(lane_out), 8'h0);
    @(negedge clk) rst_n = 1;
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1);
    // R3: data after the pulse holds many rises; alignment proves only the first counts
    run_case(0, 3, 7, 1, 4'b0000, 1'b1, "R4 trained with mixed skew", 80);
    run_case(5, 5, 5, 5, 4'b0000, 1'b1, "R4 trained with no skew", 60);
    run_case(12, 0, 5, 3, 4'b0000, 1'b1, "R5 skew equal to depth", 80);
    run_case(0, 13, 2, 1, 4'b0000, 1'b0, "R6 skew beyond depth", 60);
    run_case(2, 9, 0, 4, 4'b0000, 1'b1, "R8 retrain after error", 80);
    run_case(1, 2, 3, 4, 4'b0100, 1'b0, "R7 lane never arrives", TIMEOUT + 20);
    run_case(4, 0, 11, 6, 4'b0000, 1'b1, "R8 recovery after timeout", 80);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule